// File: doc/BRIEF.md
# Monochrome Glyph Expander

This block draws one text character into an 8-bit-per-pixel framebuffer of 1280 by 1024 pixels. A character-draw command arrives as a stream of 33 32-bit words. The block captures the whole packet, then checks its opcode word. When the opcode matches, it pulls out the glyph bitmap, the two colours and the two vertices. It then writes the glyph one pixel per clock through a plain write port: address, data and a write enable.

The glyph has 22 rows and each row is 16 bits wide. A set bitmap bit writes the foreground colour and a clear bit writes the background colour. Each row is written over the span between the x positions of the two vertices. While it draws, the block keeps a dirty bounding box that covers every row it has touched. The box grows over all commands since reset, so a display refresher knows which region to reread.

Top module: `glyph_expander`

## Requirements
- R1: When idle, the block accepts one word per cycle with `wordValid` high, 33 words per packet, and stores the first word at index 0. It draws only if word 0 equals 0x00000A21. Any other opcode produces no pixel writes and no `done` pulse, and the block returns to accepting words.
- R2: The horizontal start x is bits 29:19 of word 13, reduced modulo 1280. The end x2 is bits 29:19 of word 14, reduced the same way. The start row y is ((word13 − 63) >> 3) & 1023.
- R3: The 22 glyph rows are taken in order from words 4 through 11, then from words 30 through 32. In each word, bits 15:0 hold the earlier row and bits 31:16 hold the later row.
- R4: Within a row, column i (0 to 15) is bit i of the row halfword, so bit 0 is the leftmost pixel. Any column at 16 or beyond writes the background colour.
- R5: A set bit writes bits 7:0 of word 16 (foreground). A clear bit writes bits 7:0 of word 29 (background).
- R6: Row r writes x2 − x pixels at `fbAddr` = (y + r)·1280 + x + i, for i counting up from 0. When x2 ≤ x, the row writes nothing.
- R7: Exactly one pixel is written per cycle. A row of width w takes max(w,1) cycles. `busy` stays high from the cycle after the last word until drawing ends. `done` pulses for one cycle 22·max(w,1)+2 cycles after the last word is accepted.
- R8: After reset the dirty box is x1=2047, x2=0, y1=2047, y2=0. Every row of a drawn command, including zero-width rows, sets x1=min(x1,x), x2=max(x2,x2v), y1=min(y1,y+r) and y2=max(y2,y+r).
- R9: Words presented while `busy` is high are ignored: the next packet is captured and drawn correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wordValid | input | 1 | Packet word present |
| wordData | input | 32 | Packet word |
| busy | output | 1 | Opcode check or drawing in progress |
| fbWe | output | 1 | Framebuffer write enable |
| fbAddr | output | 21 | Framebuffer byte address |
| fbData | output | 8 | Pixel value |
| done | output | 1 | One-cycle pulse after the final row |
| dirtyX1 | output | 11 | Dirty box left edge |
| dirtyX2 | output | 11 | Dirty box right edge |
| dirtyY1 | output | 11 | Dirty box top row |
| dirtyY2 | output | 11 | Dirty box bottom row |

## Verification
Each command carries a distinct bitmap word in every slot. This means a wrong word order, a swapped halfword or a reversed bit order each put specific pixels in the wrong place. The spans used are a full 16, a narrow 5, a wide 20 (which exposes the background fill past column 15), and zero (which checks that no pixel is written while the timing and dirty box still advance). One vertex lies beyond column 1279 to test the modulo reduction, and a wrong opcode shows that nothing is drawn. Garbage words are driven during one drawing run; they would misalign the next packet if they were captured.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int COL_W = 11;
  localparam int ROW_W = 5;
  localparam int IDX_W = 6;

  typedef enum logic [1:0] {S_LOAD, S_CHECK, S_RUN} state_t;

  typedef struct packed {
    logic             loadWord;
    logic [IDX_W-1:0] wordIdx;
    logic             pixWe;
    logic             rowFirst;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } strobe_t;
endpackage

// File: rtl/glyph_ctrl.sv
module glyph_ctrl
  import glyph_pkg::*;
#(
  parameter int PKT_WORDS = 33,
  parameter int ROWS      = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wordValid,
  input  logic             pktOk,
  input  logic [COL_W-1:0] rowWidth,
  output strobe_t          strb,
  output logic             busy,
  output logic             done
);
  state_t           state;
  logic [IDX_W-1:0] wordCnt;
  logic [ROW_W-1:0] rowCnt;
  logic [COL_W-1:0] colCnt;
  logic             lastCol;

  assign lastCol = (rowWidth == '0) || (colCnt == rowWidth - COL_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_LOAD;
      wordCnt <= '0;
      rowCnt  <= '0;
      colCnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_LOAD: begin
          if (wordValid) begin
            if (wordCnt == IDX_W'(PKT_WORDS - 1)) begin
              wordCnt <= '0;
              state   <= S_CHECK;
            end else begin
              wordCnt <= wordCnt + IDX_W'(1);
            end
          end
        end
        S_CHECK: begin
          rowCnt <= '0;
          colCnt <= '0;
          state  <= pktOk ? S_RUN : S_LOAD;
        end
        S_RUN: begin
          if (lastCol) begin
            colCnt <= '0;
            if (rowCnt == ROW_W'(ROWS - 1)) begin
              rowCnt <= '0;
              state  <= S_LOAD;
              done   <= 1'b1;
            end else begin
              rowCnt <= rowCnt + ROW_W'(1);
            end
          end else begin
            colCnt <= colCnt + COL_W'(1);
          end
        end
        default: state <= S_LOAD;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.loadWord = (state == S_LOAD) && wordValid;
    strb.wordIdx  = wordCnt;
    strb.pixWe    = (state == S_RUN) && (colCnt < rowWidth);
    strb.rowFirst = (state == S_RUN) && (colCnt == '0);
    strb.row      = rowCnt;
    strb.col      = colCnt;
  end

  assign busy = (state != S_LOAD);

  // R7: done is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: done only follows a drawing cycle
  p_done_after_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state) == S_RUN);

  // R3: row counter never exceeds the glyph height while drawing
  p_row_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN) |-> (rowCnt < ROW_W'(ROWS)));

  // R1: a rejected opcode returns straight to loading
  p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_CHECK && !pktOk) |=> (state == S_LOAD && !done));
endmodule

// File: rtl/glyph_dp.sv
module glyph_dp
  import glyph_pkg::*;
#(
  parameter int          FB_W      = 1280,
  parameter int          PKT_WORDS = 33,
  parameter int          ADDR_W    = 21,
  parameter logic [31:0] OPCODE    = 32'h0000_0A21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       wordData,
  input  strobe_t           strb,
  output logic              pktOk,
  output logic [COL_W-1:0]  rowWidth,
  output logic              fbWe,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [7:0]        fbData,
  output logic [COL_W-1:0]  dirtyX1,
  output logic [COL_W-1:0]  dirtyX2,
  output logic [COL_W-1:0]  dirtyY1,
  output logic [COL_W-1:0]  dirtyY2
);
  localparam int IDX_V1     = 13;
  localparam int IDX_V2     = 14;
  localparam int IDX_FG     = 16;
  localparam int IDX_BG     = 29;
  localparam int IDX_LO     = 4;
  localparam int IDX_HI     = 30;
  localparam int SPLIT_ROWS = 16;
  localparam int GLYPH_W    = 16;
  localparam int X_LSB      = 19;
  localparam int Y_BIAS     = 63;

  logic [31:0] pktMem [PKT_WORDS];

  always_ff @(posedge clk) begin
    if (strb.loadWord) pktMem[strb.wordIdx] <= wordData;
  end

  assign pktOk = (pktMem[0] == OPCODE);

  // vertex decode
  logic [COL_W-1:0] xRaw, x2Raw, xMod, x2Mod;
  logic [9:0]       yVal;
  assign xRaw  = pktMem[IDX_V1][X_LSB +: COL_W];
  assign x2Raw = pktMem[IDX_V2][X_LSB +: COL_W];
  assign xMod  = (xRaw  >= COL_W'(FB_W)) ? xRaw  - COL_W'(FB_W) : xRaw;
  assign x2Mod = (x2Raw >= COL_W'(FB_W)) ? x2Raw - COL_W'(FB_W) : x2Raw;
  assign yVal  = 10'((pktMem[IDX_V1] - 32'(Y_BIAS)) >> 3);
  assign rowWidth = (x2Mod > xMod) ? x2Mod - xMod : '0;

  // bitmap row selection
  logic [IDX_W-1:0] bmIdx;
  logic [31:0]      bmWord;
  logic [15:0]      rowBits;
  logic             pixBit;
  always_comb begin
    if (strb.row < ROW_W'(SPLIT_ROWS))
      bmIdx = IDX_W'(IDX_LO) + IDX_W'(strb.row >> 1);
    else
      bmIdx = IDX_W'(IDX_HI) + IDX_W'((strb.row - ROW_W'(SPLIT_ROWS)) >> 1);
  end
  assign bmWord  = pktMem[bmIdx];
  assign rowBits = strb.row[0] ? bmWord[31:16] : bmWord[15:0];
  assign pixBit  = (strb.col < COL_W'(GLYPH_W)) && rowBits[strb.col[3:0]];

  // write port
  logic [COL_W-1:0] rowY;
  assign rowY   = COL_W'(yVal) + COL_W'(strb.row);
  assign fbWe   = strb.pixWe;
  assign fbData = pixBit ? pktMem[IDX_FG][7:0] : pktMem[IDX_BG][7:0];
  assign fbAddr = ADDR_W'(rowY) * ADDR_W'(FB_W) + ADDR_W'(xMod) + ADDR_W'(strb.col);

  // dirty bounding box
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dirtyX1 <= '1;
      dirtyX2 <= '0;
      dirtyY1 <= '1;
      dirtyY2 <= '0;
    end else if (strb.rowFirst) begin
      if (xMod  < dirtyX1) dirtyX1 <= xMod;
      if (x2Mod > dirtyX2) dirtyX2 <= x2Mod;
      if (rowY  < dirtyY1) dirtyY1 <= rowY;
      if (rowY  > dirtyY2) dirtyY2 <= rowY;
    end
  end

  // R5: every written pixel carries one of the two packet colours
  p_colour_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fbWe |-> (fbData == pktMem[IDX_FG][7:0] || fbData == pktMem[IDX_BG][7:0]));

  // R4: columns past the glyph width get the background colour
  p_pad_bg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fbWe && strb.col >= COL_W'(GLYPH_W)) |-> fbData == pktMem[IDX_BG][7:0]);

  // R8: once a row is recorded the vertical extent is well ordered
  p_dirty_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rowFirst |=> dirtyY1 <= dirtyY2);

  // R6: writes stay inside the span
  p_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fbWe |-> strb.col < rowWidth);
endmodule

// File: rtl/glyph_expander.sv
module glyph_expander
  import glyph_pkg::*;
#(
  parameter int          FB_W      = 1280,
  parameter int          FB_H      = 1024,
  parameter int          PKT_WORDS = 33,
  parameter int          ROWS      = 22,
  parameter logic [31:0] OPCODE    = 32'h0000_0A21,
  localparam int         ADDR_W    = $clog2(FB_W * (FB_H + ROWS))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wordValid,
  input  logic [31:0]       wordData,
  output logic              busy,
  output logic              fbWe,
  output logic [ADDR_W-1:0] fbAddr,
  output logic [7:0]        fbData,
  output logic              done,
  output logic [COL_W-1:0]  dirtyX1,
  output logic [COL_W-1:0]  dirtyX2,
  output logic [COL_W-1:0]  dirtyY1,
  output logic [COL_W-1:0]  dirtyY2
);
  strobe_t          strb;
  logic             pktOk;
  logic [COL_W-1:0] rowWidth;

  glyph_ctrl #(.PKT_WORDS(PKT_WORDS), .ROWS(ROWS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wordValid(wordValid), .pktOk(pktOk),
    .rowWidth(rowWidth), .strb(strb), .busy(busy), .done(done)
  );

  glyph_dp #(.FB_W(FB_W), .PKT_WORDS(PKT_WORDS), .ADDR_W(ADDR_W), .OPCODE(OPCODE)) u_dp (
    .clk(clk), .rst_n(rst_n), .wordData(wordData), .strb(strb),
    .pktOk(pktOk), .rowWidth(rowWidth), .fbWe(fbWe), .fbAddr(fbAddr),
    .fbData(fbData), .dirtyX1(dirtyX1), .dirtyX2(dirtyX2),
    .dirtyY1(dirtyY1), .dirtyY2(dirtyY2)
  );
endmodule

// File: tb/glyph_expander_test.sv
module glyph_expander_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        busy, fbWe, done;
  logic [20:0] fbAddr;
  logic [7:0]  fbData;
  logic [10:0] dirtyX1, dirtyX2, dirtyY1, dirtyY2;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [31:0] pkt [33];
  int expX, expX2, expY, expW;
  int dX1 = 2047, dX2 = 0, dY1 = 2047, dY2 = 0;

  always #10 clk = ~clk;

  glyph_expander uut (
    .clk(clk), .rst_n(rst_n), .wordValid(wordValid), .wordData(wordData),
    .busy(busy), .fbWe(fbWe), .fbAddr(fbAddr), .fbData(fbData), .done(done),
    .dirtyX1(dirtyX1), .dirtyX2(dirtyX2), .dirtyY1(dirtyY1), .dirtyY2(dirtyY2)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int vtx(input int x, input int y);
    return (x << 19) + (y << 3) + 63;
  endfunction

  task automatic buildPkt(input int x, input int y, input int x2, input int seed,
                          input logic [31:0] opc);
    for (int k = 0; k < 33; k++) pkt[k] = (32'(k) * 32'h9E37_79B1) ^ 32'(seed);
    pkt[0]  = opc;
    pkt[13] = 32'(vtx(x, y));
    pkt[14] = 32'(vtx(x2, y));
    pkt[16] = 32'h00FF_FF00 | 32'(8'hA0 + seed[3:0]);
    pkt[29] = 32'h0077_0000 | 32'(8'h10 + seed[3:0]);
    expX  = x  % 1280;
    expX2 = x2 % 1280;
    expY  = y;
    expW  = (expX2 > expX) ? expX2 - expX : 0;
  endtask

  task automatic sendPkt();
    for (int k = 0; k < 33; k++) begin
      @(negedge clk);
      wordValid = 1'b1;
      wordData  = pkt[k];
    end
  endtask

  function automatic logic [7:0] expPix(input int r, input int i);
    logic [31:0] w;
    logic [15:0] h;
    if (i >= 16) return pkt[29][7:0];
    w = (r < 16) ? pkt[4 + r / 2] : pkt[30 + (r - 16) / 2];
    h = (r % 2 == 1) ? w[31:16] : w[15:0];
    return h[i] ? pkt[16][7:0] : pkt[29][7:0];
  endfunction

  task automatic checkDirty(input string tag);
    check(dirtyX1 == 11'(dX1), {tag, " R8 dirtyX1"}, int'(dirtyX1), dX1);
    check(dirtyX2 == 11'(dX2), {tag, " R8 dirtyX2"}, int'(dirtyX2), dX2);
    check(dirtyY1 == 11'(dY1), {tag, " R8 dirtyY1"}, int'(dirtyY1), dY1);
    check(dirtyY2 == 11'(dY2), {tag, " R8 dirtyY2"}, int'(dirtyY2), dY2);
  endtask

  // Send the current packet, collect writes, compare against the model.
  task automatic runCmd(input string tag, input bit garbage);
    logic [7:0] seen [int];
    int cnt = 1, doneAt = -1, writes = 0, bad = 0, badAct = 0, badExp = 0;
    int cyc;
    sendPkt();
    @(negedge clk);
    wordValid = 1'b0;
    while (cnt < 40000) begin
      if (fbWe) begin
        seen[int'(fbAddr)] = fbData;
        writes++;
      end
      if (done) begin
        doneAt = cnt;
        break;
      end
      if (garbage && cnt >= 3 && cnt < 12) begin
        wordValid = 1'b1;
        wordData  = 32'hDEAD_0000 + 32'(cnt);
      end else begin
        wordValid = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    wordValid = 1'b0;
    for (int r = 0; r < 22; r++) begin
      for (int i = 0; i < expW; i++) begin
        int a = (expY + r) * 1280 + expX + i;
        if (!seen.exists(a)) begin
          if (bad == 0) begin badAct = -1; badExp = a; end
          bad++;
        end else if (seen[a] != expPix(r, i)) begin
          if (bad == 0) begin badAct = int'(seen[a]); badExp = int'(expPix(r, i)); end
          bad++;
        end
      end
    end
    check(writes == 22 * expW, {tag, " R6 write count"}, writes, 22 * expW);
    check(bad == 0, {tag, " R3 R4 R5 R6 pixel value/address"}, badAct, badExp);
    cyc = 22 * ((expW > 0) ? expW : 1) + 2;
    check(doneAt == cyc, {tag, " R7 done timing"}, doneAt, cyc);
    @(negedge clk);
    check(!done && !busy, {tag, " R7 done single pulse, idle"}, int'({done, busy}), 0);
    if (expX < dX1) dX1 = expX;
    if (expX2 > dX2) dX2 = expX2;
    if (expY < dY1) dY1 = expY;
    if (expY + 21 > dY2) dY2 = expY + 21;
    checkDirty(tag);
  endtask

  task automatic testReset();
    check(!busy, "reset R7 busy", int'(busy), 0);
    check(!done && !fbWe, "reset R7 outputs", int'({done, fbWe}), 0);
    checkDirty("reset");
  endtask

  task automatic testBasic();
    buildPkt(100, 50, 116, 1, 32'h0000_0A21);
    runCmd("basic16", 1'b0);
  endtask

  task automatic testGarbage();
    buildPkt(640, 500, 645, 2, 32'h0000_0A21);
    runCmd("narrow5 R9 garbage", 1'b1);
    buildPkt(300, 200, 312, 3, 32'h0000_0A21);
    runCmd("after-garbage R9", 1'b0);
  endtask

  task automatic testWide();
    buildPkt(10, 0, 30, 4, 32'h0000_0A21);
    runCmd("wide20 R4", 1'b0);
  endtask

  task automatic testModulo();
    buildPkt(1300, 1000, 1310, 5, 32'h0000_0A21);
    check(expX == 20 && expX2 == 30, "modulo R2 model", expX, 20);
    runCmd("modulo R2", 1'b0);
  endtask

  task automatic testZeroWidth();
    buildPkt(200, 30, 190, 6, 32'h0000_0A21);
    runCmd("zero-width R6", 1'b0);
  endtask

  task automatic testBadOpcode();
    int writes = 0, dones = 0;
    buildPkt(5, 5, 21, 7, 32'h0000_0A22);
    sendPkt();
    @(negedge clk);
    wordValid = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (fbWe) writes++;
      if (done) dones++;
      @(negedge clk);
    end
    check(writes == 0, "bad opcode R1 writes", writes, 0);
    check(dones == 0, "bad opcode R1 done", dones, 0);
    check(!busy, "bad opcode R1 idle", int'(busy), 0);
    checkDirty("bad opcode R1");
    buildPkt(400, 100, 416, 8, 32'h0000_0A21);
    runCmd("after bad opcode R1", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testGarbage();
    testWide();
    testModulo();
    testZeroWidth();
    testBadOpcode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule